// File: doc/BRIEF.md
# Tone Detection Guard-Time Validator

This block sits behind a tone-pair detector and decides when a raw "tone present" indication is trustworthy enough to register a digit. The raw early-steering input has to stay high for a programmable number of clock cycles (the present guard) before the decoded 4-bit code is captured. It then has to stay low for a separate programmable number of cycles (the absent guard) before the block treats the gap as a real inter-digit pause. Short bursts are rejected. Short dropouts inside a tone are bridged, so the registered digit survives them.

After a code is captured, a delayed steering flag rises once a programmable settling count has elapsed. The flag can be seen in a two-bit status output. When interrupt mode is on, the flag also drives an active-low interrupt, which a read strobe on the receive register acknowledges. A guard-time output follows the raw input while a digit is registered. The three cycle counts sit in registers that are written only while the block is idle. The minimum tone length that is recognised equals the upstream detection delay plus the present guard.

Top module: `tone_guard_validator`

## Requirements
- R1: After a synchronous reset, gt_out and dsf_out are 0, rx_data is 0, status is 0 and irq_n is 1.
- R2: With present guard P, a digit is accepted at the clock edge that samples est_raw high for the (P+1)-th consecutive time. At that edge rx_data takes the value of code_in.
- R3: A high burst on est_raw of P samples or fewer captures nothing. It leaves rx_data, gt_out and dsf_out unchanged.
- R4: gt_out is 1 after an edge only if that edge accepted a digit, or if a digit was already registered (settling, held or pause qualification) and est_raw was sampled high there. Otherwise gt_out is 0.
- R5: With settle count S, dsf_out rises S edges after the capture edge (at the capture edge when S is 0). It stays high until the pause is validated.
- R6: While a digit is registered, a low gap on est_raw of A samples or fewer (A = absent guard) is ignored. dsf_out stays high, and rx_data keeps its value even if code_in changes.
- R7: A+1 consecutive low samples after a held digit validate the pause. dsf_out clears at that edge, and the next tone may capture a new code.
- R8: status bit 0 is the flag and status bit 1 is the interrupt request. The request is set at the edge where the flag rises. It clears at a rd_strobe edge or when the flag clears. irq_n is 0 exactly when the request is set and irq_en was 1 at the same edge.
- R9: cfg_load loads cfg_present, cfg_absent and cfg_settle only at an edge where the block is idle; at any other time it is ignored. A loaded count of zero makes the matching transition immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| est_raw | input | 1 | Raw early-steering tone-present indication |
| code_in | input | CODE_W | Decoded tone-pair code |
| cfg_load | input | 1 | Load guard/settle counts (idle only) |
| cfg_present | input | CNT_W | Present guard count |
| cfg_absent | input | CNT_W | Absent guard count |
| cfg_settle | input | CNT_W | Settling delay count |
| irq_en | input | 1 | Interrupt mode enable |
| rd_strobe | input | 1 | Receive register read, acknowledges the interrupt |
| gt_out | output | 1 | Guard-time output |
| dsf_out | output | 1 | Delayed steering flag |
| rx_data | output | CODE_W | Receive data register |
| status | output | 2 | {interrupt request, flag} |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The validator is driven with high bursts that end one sample before acceptance and with bursts that are long enough. This separates an off-by-one in the present count from correct acceptance. Low gaps one sample short of the absent guard, and gaps long enough to count as a pause, separate a bridged dropout from a real pause. During the bridged gap the code input changes, which exposes any re-capture. A configuration write during a held digit, followed by zero guard and settle counts loaded while idle, separates gated from ungated loading and checks the immediate transitions. Interrupt mode is exercised both on and off, with a read during the flag, to tell request acknowledgement apart from flag clearing.

// File: rtl/tgv_pkg.sv
package tgv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_QON    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_HELD   = 3'd3,
    ST_QOFF   = 3'd4
  } tgv_state_e;
endpackage

// File: rtl/tgv_cfg_regs.sv
module tgv_cfg_regs #(
  parameter int CNT_W       = 16,
  parameter int DEF_PRESENT = 4,
  parameter int DEF_ABSENT  = 3,
  parameter int DEF_SETTLE  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_ok,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_present,
  input  logic [CNT_W-1:0] cfg_absent,
  input  logic [CNT_W-1:0] cfg_settle,
  output logic [CNT_W-1:0] th_present,
  output logic [CNT_W-1:0] th_absent,
  output logic [CNT_W-1:0] th_settle
);
  always_ff @(posedge clk) begin
    if (rst) begin
      th_present <= CNT_W'(DEF_PRESENT);
      th_absent  <= CNT_W'(DEF_ABSENT);
      th_settle  <= CNT_W'(DEF_SETTLE);
    end else if (load_ok && cfg_load) begin
      th_present <= cfg_present;
      th_absent  <= cfg_absent;
      th_settle  <= cfg_settle;
    end
  end

  // counts move only through an idle-time load
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !load_ok |=> ($stable(th_present) && $stable(th_absent) && $stable(th_settle)));
  assert_cfg_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (load_ok && cfg_load) |=> (th_present == $past(cfg_present)));
endmodule

// File: rtl/tgv_steer_fsm.sv
module tgv_steer_fsm
  import tgv_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              est,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CNT_W-1:0]  th_present,
  input  logic [CNT_W-1:0]  th_absent,
  input  logic [CNT_W-1:0]  th_settle,
  output logic              idle,
  output logic              gt_q,
  output logic              dsf_q,
  output logic              dsf_rise,
  output logic              dsf_fall,
  output logic [CODE_W-1:0] rx_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tgv_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              dsf_n, gt_n, accept;
  logic [CODE_W-1:0] rx_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    dsf_n   = dsf_q;
    rx_n    = rx_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (est) begin
          if (th_present == '0) accept = 1'b1;
          else begin
            state_n = ST_QON;
            cnt_n   = ONE;
          end
        end
      end
      ST_QON: begin
        if (!est) state_n = ST_IDLE;
        else if (cnt_q >= th_present) accept = 1'b1;
        else cnt_n = cnt_q + ONE;
      end
      ST_SETTLE: begin
        if (cnt_q >= th_settle) begin
          dsf_n   = 1'b1;
          state_n = ST_HELD;
        end else cnt_n = cnt_q + ONE;
      end
      ST_HELD: begin
        if (!est) begin
          if (th_absent == '0) begin
            dsf_n   = 1'b0;
            state_n = ST_IDLE;
          end else begin
            state_n = ST_QOFF;
            cnt_n   = ONE;
          end
        end
      end
      ST_QOFF: begin
        if (est) state_n = ST_HELD;
        else if (cnt_q >= th_absent) begin
          dsf_n   = 1'b0;
          state_n = ST_IDLE;
        end else cnt_n = cnt_q + ONE;
      end
      default: state_n = ST_IDLE;
    endcase
    if (accept) begin
      rx_n = code_in;
      if (th_settle == '0) begin
        dsf_n   = 1'b1;
        state_n = ST_HELD;
      end else begin
        state_n = ST_SETTLE;
        cnt_n   = ONE;
      end
    end
    gt_n = est && (state_n == ST_SETTLE || state_n == ST_HELD || state_n == ST_QOFF);
  end

  assign dsf_rise = dsf_n & ~dsf_q;
  assign dsf_fall = dsf_q & ~dsf_n;
  assign idle     = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dsf_q   <= 1'b0;
      gt_q    <= 1'b0;
      rx_q    <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      dsf_q   <= dsf_n;
      gt_q    <= gt_n;
      rx_q    <= rx_n;
    end
  end

  // a registered digit is never overwritten before its pause is validated
  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE || state_q == ST_HELD || state_q == ST_QOFF) |=> $stable(rx_q));
  // flag only while a digit is held or its pause is being qualified
  assert_flag_held_R5: assert property (@(posedge clk) disable iff (rst)
    dsf_q |-> (state_q == ST_HELD || state_q == ST_QOFF));
  // guard output implies a registered digit
  assert_gt_region_R4: assert property (@(posedge clk) disable iff (rst)
    gt_q |-> (dsf_q || state_q == ST_SETTLE));
  // qualification counter never passes its threshold
  assert_qon_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_QON) |-> (cnt_q <= th_present));
endmodule

// File: rtl/tgv_irq_ctrl.sv
module tgv_irq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       dsf_i,
  input  logic       dsf_rise,
  input  logic       dsf_fall,
  input  logic       rd_strobe,
  input  logic       irq_en,
  output logic [1:0] status,
  output logic       irq_n
);
  logic pend_q, pend_n;

  always_comb begin
    pend_n = pend_q;
    if (dsf_rise) pend_n = 1'b1;
    else if (dsf_fall || rd_strobe) pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      pend_q <= pend_n;
      irq_n  <= ~(irq_en & pend_n);
    end
  end

  assign status = {pend_q, dsf_i};

  assert_pend_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> dsf_i);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !dsf_rise) |=> !pend_q);
  assert_irq_needs_pend_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> pend_q);
endmodule

// File: rtl/tone_guard_validator.sv
module tone_guard_validator #(
  parameter int CNT_W       = 16,
  parameter int CODE_W      = 4,
  parameter int DEF_PRESENT = 4,
  parameter int DEF_ABSENT  = 3,
  parameter int DEF_SETTLE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              est_raw,
  input  logic [CODE_W-1:0] code_in,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cfg_present,
  input  logic [CNT_W-1:0]  cfg_absent,
  input  logic [CNT_W-1:0]  cfg_settle,
  input  logic              irq_en,
  input  logic              rd_strobe,
  output logic              gt_out,
  output logic              dsf_out,
  output logic [CODE_W-1:0] rx_data,
  output logic [1:0]        status,
  output logic              irq_n
);
  logic [CNT_W-1:0] th_present, th_absent, th_settle;
  logic idle, dsf_rise, dsf_fall;

  tgv_cfg_regs #(
    .CNT_W(CNT_W), .DEF_PRESENT(DEF_PRESENT),
    .DEF_ABSENT(DEF_ABSENT), .DEF_SETTLE(DEF_SETTLE)
  ) u_cfg (
    .clk(clk), .rst(rst), .load_ok(idle), .cfg_load(cfg_load),
    .cfg_present(cfg_present), .cfg_absent(cfg_absent), .cfg_settle(cfg_settle),
    .th_present(th_present), .th_absent(th_absent), .th_settle(th_settle)
  );

  tgv_steer_fsm #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_fsm (
    .clk(clk), .rst(rst), .est(est_raw), .code_in(code_in),
    .th_present(th_present), .th_absent(th_absent), .th_settle(th_settle),
    .idle(idle), .gt_q(gt_out), .dsf_q(dsf_out),
    .dsf_rise(dsf_rise), .dsf_fall(dsf_fall), .rx_q(rx_data)
  );

  tgv_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .dsf_i(dsf_out), .dsf_rise(dsf_rise),
    .dsf_fall(dsf_fall), .rd_strobe(rd_strobe), .irq_en(irq_en),
    .status(status), .irq_n(irq_n)
  );
endmodule

// File: tb/tone_guard_validator_bench.sv
module tone_guard_validator_bench;
  localparam int CW = 16;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic est = 1'b0;
  logic [DW-1:0] code = '0;
  logic cfg_load = 1'b0;
  logic [CW-1:0] cp = '0, ca = '0, cs = '0;
  logic irq_en = 1'b0;
  logic rd = 1'b0;
  logic gt, dsf, irqn;
  logic [DW-1:0] rx;
  logic [1:0] st;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  tone_guard_validator #(
    .CNT_W(CW), .CODE_W(DW), .DEF_PRESENT(4), .DEF_ABSENT(3), .DEF_SETTLE(2)
  ) u_tone_guard_validator (
    .clk(clk), .rst(rst), .est_raw(est), .code_in(code), .cfg_load(cfg_load),
    .cfg_present(cp), .cfg_absent(ca), .cfg_settle(cs), .irq_en(irq_en),
    .rd_strobe(rd), .gt_out(gt), .dsf_out(dsf), .rx_data(rx), .status(st),
    .irq_n(irqn)
  );

  // behavioural reference: phase 0 idle, 1 counting high, 2 settling,
  // 3 digit held, 4 counting low
  int phase, run, gp, ga, gs;
  bit  m_gt, m_dsf, m_pend, m_irqn;
  logic [DW-1:0] m_rx;

  task automatic take_digit();
    m_rx = code;
    if (gs == 0) begin m_dsf = 1; phase = 3; end
    else begin phase = 2; run = 1; end
  endtask

  task automatic check(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit was;
    if (rst) begin
      phase = 0; run = 0; gp = 4; ga = 3; gs = 2;
      m_gt = 0; m_dsf = 0; m_pend = 0; m_irqn = 1; m_rx = '0;
    end else begin
      was = m_dsf;
      case (phase)
        0: begin
          if (est) begin
            if (gp == 0) take_digit();
            else begin phase = 1; run = 1; end
          end
          if (cfg_load) begin gp = cp; ga = ca; gs = cs; end
        end
        1: if (!est) phase = 0;
           else if (run >= gp) take_digit();
           else run++;
        2: if (run >= gs) begin m_dsf = 1; phase = 3; end
           else run++;
        3: if (!est) begin
             if (ga == 0) begin m_dsf = 0; phase = 0; end
             else begin phase = 4; run = 1; end
           end
        default: if (est) phase = 3;
           else if (run >= ga) begin m_dsf = 0; phase = 0; end
           else run++;
      endcase
      m_gt = est && (phase >= 2);
      if (m_dsf && !was) m_pend = 1;
      else if (!m_dsf || rd) m_pend = 0;
      m_irqn = !(irq_en && m_pend);
    end
    #1;
    // per-cycle comparison: R4 guard, R5 flag, R2 data, R8 status/interrupt
    check("R4 gt_out", gt, m_gt);
    check("R5 dsf_out", dsf, m_dsf);
    check("R2 rx_data", rx, m_rx);
    check("R8 status", st, {m_pend, m_dsf});
    check("R8 irq_n", irqn, m_irqn);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic hi(input int n, input logic [DW-1:0] c);
    @(negedge clk); est = 1; code = c; cyc(n - 1);
  endtask
  task automatic lo(input int n);
    @(negedge clk); est = 0; cyc(n - 1);
  endtask
  task automatic load(input int p, input int a, input int s);
    @(negedge clk); cfg_load = 1; cp = CW'(p); ca = CW'(a); cs = CW'(s);
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic stimulus();
    cyc(3);
    @(negedge clk); rst = 0;
    // R1: outputs after reset
    check("R1 reset gt/dsf/rx/status/irq_n", {gt, dsf, rx, st, irqn}, 9'b000000001);
    tag = "R9"; load(5, 4, 2);
    irq_en = 1;
    tag = "R3"; hi(5, 4'h3); lo(8);
    check("R3 no capture after short burst", rx, 0);
    tag = "R2"; hi(12, 4'h5);
    check("R2 captured code", rx, 5);
    tag = "R6"; lo(4); code = 4'h9; hi(4, 4'h9);
    check("R6 data kept over dropout", rx, 5);
    check("R6 flag kept over dropout", dsf, 1);
    tag = "R9"; load(0, 0, 0);   // ignored: digit held
    tag = "R8"; @(negedge clk); rd = 1; @(negedge clk); rd = 0;
    check("R8 read clears request", irqn, 1);
    tag = "R7"; lo(8);
    check("R7 flag cleared after pause", dsf, 0);
    hi(10, 4'hA); lo(8);
    check("R7 next digit captured", rx, 10);
    tag = "R9"; load(0, 0, 0);
    hi(3, 4'h3); lo(2);
    check("R9 zero counts capture", rx, 3);
    tag = "R8"; irq_en = 0; hi(3, 4'h7); lo(3);
    irq_en = 1; hi(1, 4'h1); lo(1); hi(2, 4'hC); lo(3);
    check("R8 final digit", rx, 12);
  endtask

  initial begin
    bit wd = 0;
    fork
      stimulus();
      begin repeat (100000) @(posedge clk); wd = 1; end
    join_any
    disable fork;
    if (wd) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule